// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Window

This block sits in an FPGA as the target of a microcontroller's external bus, where address and data share one set of 20 lines. It opens a memory-mapped window of up to 1 MB onto a co-processor. A transaction opens on the bus clock edge where the single chip select and the transfer-start strobe are both low. On that edge the block latches the address from the shared lines. It then counts a fixed number of wait cycles and runs one or more data beats against a plain back-end port. That port has address, write data, write strobe, read strobe and read data.

The master gets no acknowledge back. It runs with a fixed auto-acknowledge wait-state count, and the `WAIT_CYCLES` parameter must be set to the same value. Burst and transfer size are not signalled per transaction. They come from static strap inputs, so every transaction has the same shape. Writes always cover the whole port width, because no byte-lane masks exist.

On a read, the block drives the shared lines only while chip select and output enable are both low. The driver enable is registered, so it follows those inputs by one cycle.

Top module: `muxbus_slave`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after that edge, `bus_oe`, `be_we` and `be_re` are all 0.
- R2: When idle, the block starts a transaction only on an edge where `cs_n`=0 and `ts_n`=0. It latches `bus_in[19:0]` as the base address on that edge. A `ts_n` pulse while `cs_n`=1 starts nothing.
- R3: The first data beat, with `be_we` or `be_re` high, occupies the cycle `WAIT_CYCLES`+1 cycles after the address-phase cycle.
- R4: A transaction has 4 beats when `cfg_burst`=1 and `cfg_size`=2'b11 on the address edge, and 1 beat in every other case. Beats occupy consecutive cycles.
- R5: `be_addr` equals the latched base on the first beat. It rises by `DW`/8 on each later beat and wraps modulo 2^20.
- R6: A transaction with `rw_n`=0 on the address edge is a write. During each beat `be_we`=1, `be_re`=0, and `be_wdata` equals `bus_in[DW-1:0]` at full width.
- R7: A transaction with `rw_n`=1 is a read. During each beat `be_re`=1, `be_we`=0, and the cycle after each beat `bus_out` holds that beat's `be_rdata`, with the upper bits at zero.
- R8: `bus_oe` is 1 in a cycle exactly when, in the previous cycle, a read transaction was selected and both `cs_n` and `oe_n` were 0.
- R9: When `cs_n` goes high during a transaction, the transaction ends. No further strobe is issued until a new address phase.
- R10: A `ts_n` pulse during a transaction's wait or data cycles is ignored. The latched address is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock from the master |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 20 | Shared address/data lines as seen from the pads |
| bus_out | output | 20 | Read data driven toward the shared lines |
| bus_oe | output | 1 | Pad driver enable for `bus_out` |
| cs_n | input | 1 | Chip select, active low |
| ts_n | input | 1 | Transfer start, active low |
| rw_n | input | 1 | 1 = read, 0 = write, sampled on the address edge |
| oe_n | input | 1 | Master output enable, active low |
| cfg_burst | input | 1 | Static strap: burst operation enabled |
| cfg_size | input | 2 | Static strap: transfer size, 2'b11 = line |
| be_addr | output | 20 | Back-end byte address |
| be_wdata | output | DW | Back-end write data |
| be_we | output | 1 | Back-end write strobe |
| be_re | output | 1 | Back-end read strobe |
| be_rdata | input | DW | Back-end read data, valid in the cycle of `be_re` |

## Verification
The bench builds the block with a 16-bit port and two wait cycles. This makes the address step 2 bytes, and the first strobe falls three cycles after the address phase, far enough out that an off-by-one in the wait counter shows. With these values a line burst starting near the top of the 1 MB window wraps to low addresses. An abort and a stray start pulse can also land inside the wait window, before any beat has happened.

// File: rtl/muxbus_pkg.sv
// Package: shared phase type and the strap decoding for the bus slave.
// Assumes the line-size strap code selects a four-beat burst.
package muxbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    localparam logic [1:0] SIZE_LINE  = 2'b11;
    localparam int         LINE_BEATS = 4;

    // Number of data beats, minus one, for the given strap setting.
    function automatic logic [1:0] beats_m1(input logic burst, input logic [1:0] size);
        return (burst && size == SIZE_LINE) ? 2'(LINE_BEATS - 1) : 2'd0;
    endfunction

endpackage

// File: rtl/muxbus_seq.sv
// Sequencer: walks idle -> wait -> data for each transaction.
// Assumes WAIT_CYCLES >= 1 and matches the master's wait-state setting.
// Chip select going high ends any transaction at once.
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int WAIT_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       ts_n,
    input  logic       rw_n,
    input  logic       cfg_burst,
    input  logic [1:0] cfg_size,
    output phase_t     phase,
    output logic       addr_load,
    output logic       beat,
    output logic       is_read
);
    localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);

    logic [CW-1:0] wait_cnt;
    logic [1:0]    beats_left;

    // A new transaction opens only from idle with select and start both low.
    assign addr_load = (phase == PH_IDLE) && !cs_n && !ts_n;
    // A beat happens in data phase while still selected.
    assign beat      = (phase == PH_DATA) && !cs_n;

    // Phase, wait counter and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            wait_cnt   <= '0;
            beats_left <= '0;
            is_read    <= 1'b0;
        end else if (addr_load) begin
            phase      <= PH_WAIT;
            wait_cnt   <= CW'(WAIT_CYCLES - 1);
            beats_left <= beats_m1(cfg_burst, cfg_size);
            is_read    <= rw_n;
        end else if (phase != PH_IDLE && cs_n) begin
            phase <= PH_IDLE;
        end else if (phase == PH_WAIT) begin
            if (wait_cnt == '0) phase <= PH_DATA;
            else                wait_cnt <= wait_cnt - 1'b1;
        end else if (phase == PH_DATA) begin
            if (beats_left == '0) phase <= PH_IDLE;
            else                  beats_left <= beats_left - 1'b1;
        end
    end

    AST_START_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (phase == PH_WAIT)); // R2

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && phase != PH_IDLE) |=> (phase == PH_IDLE)); // R9

endmodule

// File: rtl/muxbus_addr.sv
// Address generator: latches the base from the shared lines, then steps
// by the port width on each beat. Wraps within the address width.
module muxbus_addr #(
    parameter int AW   = 20,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    output logic [AW-1:0] addr
);
    // Hold, load or advance the current beat address.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr <= '0;
        else if (load)    addr <= load_val;
        else if (step_en) addr <= addr + AW'(STEP);
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load) |=> (addr == $past(addr) + AW'(STEP))); // R5

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load) |=> $stable(addr)); // R10

endmodule

// File: rtl/muxbus_rd_drive.sv
// Read driver: registers read data per beat and controls the pad enable.
// The enable follows select and output enable one cycle late, and only
// for a transaction that opened as a read.
module muxbus_rd_drive #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_txn,
    input  logic          rw_n,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          capture,
    input  logic [DW-1:0] rdata_in,
    output logic          drive_en,
    output logic [DW-1:0] rdata_q
);
    logic rd_sel;

    // Remember whether the open transaction is a read, until deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_sel <= 1'b0;
        else if (open_txn) rd_sel <= rw_n;
        else if (cs_n)     rd_sel <= 1'b0;
    end

    // Registered pad enable.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_en <= 1'b0;
        else        drive_en <= rd_sel && !cs_n && !oe_n;
    end

    // Capture back-end read data on each read beat.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= rdata_in;
    end

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || oe_n) |=> !drive_en); // R8

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata_q)); // R7

endmodule

// File: rtl/muxbus_slave.sv
// Top: slave window on a shared address/data bus with one chip select.
// Gives no acknowledge. Every transaction follows the strap-selected
// shape after a fixed WAIT_CYCLES count. Writes are always full width.
// Assumes DW is 8 or 16 and smaller than AW.
module muxbus_slave
    import muxbus_pkg::*;
#(
    parameter int AW          = 20,
    parameter int DW          = 16,
    parameter int WAIT_CYCLES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_in,
    output logic [AW-1:0] bus_out,
    output logic          bus_oe,
    input  logic          cs_n,
    input  logic          ts_n,
    input  logic          rw_n,
    input  logic          oe_n,
    input  logic          cfg_burst,
    input  logic [1:0]    cfg_size,
    output logic [AW-1:0] be_addr,
    output logic [DW-1:0] be_wdata,
    output logic          be_we,
    output logic          be_re,
    input  logic [DW-1:0] be_rdata
);
    localparam int PORT_BYTES = DW / 8;

    phase_t        phase;
    logic          addr_load;
    logic          beat;
    logic          is_read;
    logic [DW-1:0] rdata_q;

    muxbus_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .ts_n      (ts_n),
        .rw_n      (rw_n),
        .cfg_burst (cfg_burst),
        .cfg_size  (cfg_size),
        .phase     (phase),
        .addr_load (addr_load),
        .beat      (beat),
        .is_read   (is_read)
    );

    muxbus_addr #(.AW(AW), .STEP(PORT_BYTES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (bus_in),
        .step_en  (beat),
        .addr     (be_addr)
    );

    muxbus_rd_drive #(.DW(DW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_txn (addr_load),
        .rw_n     (rw_n),
        .cs_n     (cs_n),
        .oe_n     (oe_n),
        .capture  (be_re),
        .rdata_in (be_rdata),
        .drive_en (bus_oe),
        .rdata_q  (rdata_q)
    );

    // Back-end strobes and full-width write data.
    assign be_we    = beat && !is_read;
    assign be_re    = beat && is_read;
    assign be_wdata = bus_in[DW-1:0];
    assign bus_out  = {{(AW - DW){1'b0}}, rdata_q};

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(be_we && be_re)); // R6

    AST_CS_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(be_we || be_re)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !(be_we || be_re)); // R3

endmodule

// File: tb/muxbus_slave_test.sv
module muxbus_slave_test;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int W  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_in = '0;
    logic [AW-1:0] bus_out;
    logic          bus_oe;
    logic          cs_n = 1'b1, ts_n = 1'b1, rw_n = 1'b1, oe_n = 1'b1;
    logic          cfg_burst = 1'b0;
    logic [1:0]    cfg_size = 2'b00;
    logic [AW-1:0] be_addr;
    logic [DW-1:0] be_wdata;
    logic          be_we, be_re;
    logic [DW-1:0] be_rdata;

    int checks = 0, failures = 0, cyc = 0;
    int n_we, n_re, first_cyc, addr_cyc;
    logic [AW-1:0] last_we_addr, last_re_addr, last_out;
    logic [DW-1:0] mem [int];

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction
    assign be_rdata = rd_val(be_addr);

    muxbus_slave #(.AW(AW), .DW(DW), .WAIT_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .cs_n(cs_n), .ts_n(ts_n), .rw_n(rw_n), .oe_n(oe_n),
        .cfg_burst(cfg_burst), .cfg_size(cfg_size),
        .be_addr(be_addr), .be_wdata(be_wdata), .be_we(be_we), .be_re(be_re),
        .be_rdata(be_rdata)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model: phase 0 idle, 1 wait, 2 data.
    int            m_phase = 0, m_cnt = 0, m_beats = 0;
    bit            m_rd = 0, m_rdsel = 0, m_oe = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_rdata = '0;

    always @(posedge clk) begin
        bit beat, start, n_oe;
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_rd = 0; m_rdsel = 0; m_oe = 0; m_addr = '0; m_rdata = '0;
        end else begin
            beat  = (m_phase == 2) && !cs_n;
            start = (m_phase == 0) && !cs_n && !ts_n;
            n_oe  = m_rdsel && !cs_n && !oe_n;
            if (beat && m_rd) m_rdata = rd_val(m_addr);
            if (start) m_rdsel = rw_n; else if (cs_n) m_rdsel = 0;
            if (start) m_addr = bus_in; else if (beat) m_addr = m_addr + AW'(DW / 8);
            if (start) begin
                m_rd = rw_n; m_phase = 1; m_cnt = W - 1;
                m_beats = (cfg_burst && cfg_size == 2'b11) ? 3 : 0;
            end else if (m_phase != 0 && cs_n) m_phase = 0;
            else if (m_phase == 1) begin
                if (m_cnt == 0) m_phase = 2; else m_cnt--;
            end else if (m_phase == 2) begin
                if (m_beats == 0) m_phase = 0; else m_beats--;
            end
            m_oe = n_oe;
        end
    end

    // Compare and monitor away from the active edge.
    always @(negedge clk) begin
        bit ewe, ere;
        if (rst_n) begin
            ewe = (m_phase == 2) && !m_rd && !cs_n;
            ere = (m_phase == 2) && m_rd && !cs_n;
            check(be_we === ewe, "R6 be_we", be_we, ewe);
            check(be_re === ere, "R7 be_re", be_re, ere);
            check(bus_oe === m_oe, "R8 bus_oe", bus_oe, m_oe);
            if (ewe || ere) check(be_addr === m_addr, "R5 be_addr", be_addr, m_addr);
            if (ewe) check(be_wdata === bus_in[DW-1:0], "R6 be_wdata", be_wdata, bus_in[DW-1:0]);
            if (m_oe) check(bus_out === {4'h0, m_rdata}, "R7 bus_out", bus_out, {4'h0, m_rdata});
            if (be_we) begin
                n_we++; last_we_addr = be_addr; mem[int'(be_addr)] = be_wdata;
                if (first_cyc < 0) first_cyc = cyc;
            end
            if (be_re) begin
                n_re++; last_re_addr = be_addr;
                if (first_cyc < 0) first_cyc = cyc;
            end
            if (bus_oe) last_out = bus_out;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic txn(input logic [AW-1:0] a, input bit rd, input bit burst,
                       input logic [1:0] sz, input logic [15:0] wb,
                       input bit abort, input bit stray);
        int nb = (burst && sz == 2'b11) ? 4 : 1;
        n_we = 0; n_re = 0; first_cyc = -1;
        step();
        cfg_burst = burst; cfg_size = sz;
        cs_n = 0; ts_n = 0; rw_n = rd; bus_in = a; oe_n = 1; addr_cyc = cyc;
        for (int i = 0; i < W; i++) begin
            step();
            ts_n = 1; bus_in = '0; oe_n = rd ? 1'b0 : 1'b1;
            if (i == 0 && stray) begin ts_n = 0; bus_in = a ^ 20'h00F00; end
            if (i == 0 && abort) cs_n = 1;
        end
        for (int k = 0; k < nb; k++) begin
            step();
            ts_n = 1; bus_in = rd ? '0 : {4'h0, wb + 16'(k)};
        end
        step();
        bus_in = '0;
        step();
        cs_n = 1; oe_n = 1; ts_n = 1;
        step();
    endtask

    initial begin
        #160000;
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        first_cyc = -1; n_we = 0; n_re = 0;
        repeat (3) step();
        @(negedge clk);
        check(bus_oe === 0 && be_we === 0 && be_re === 0, "R1 reset outputs",
              {bus_oe, be_we, be_re}, 0);
        step(); rst_n = 1;
        @(negedge clk);
        check(bus_oe === 0 && be_we === 0 && be_re === 0, "R1 after reset",
              {bus_oe, be_we, be_re}, 0);

        // R2: start pulse without select is ignored
        n_we = 0; n_re = 0;
        step(); ts_n = 0; rw_n = 0; bus_in = 20'h00ABC;
        step(); ts_n = 1;
        repeat (W + 4) step();
        check(n_we == 0 && n_re == 0, "R2 ts without cs", n_we + n_re, 0);

        // R2/R3: single write
        txn(20'h12340, 0, 0, 2'b00, 16'h7777, 0, 0);
        check(last_we_addr == 20'h12340, "R2 latched address", last_we_addr, 20'h12340);
        check(first_cyc - addr_cyc == W + 1, "R3 first beat cycle", first_cyc - addr_cyc, W + 1);
        check(n_we == 1, "R4 single write beats", n_we, 1);

        // R4: no burst with line size -> one beat
        txn(20'h00456, 1, 0, 2'b11, 16'h0, 0, 0);
        check(n_re == 1, "R4 non-burst line", n_re, 1);
        check(first_cyc - addr_cyc == W + 1, "R3 read first beat", first_cyc - addr_cyc, W + 1);

        // R4/R5/R6: burst line write
        txn(20'h20010, 0, 1, 2'b11, 16'h1000, 0, 0);
        check(n_we == 4, "R4 burst write beats", n_we, 4);
        check(last_we_addr == 20'h20016, "R5 burst last addr", last_we_addr, 20'h20016);
        check(mem[int'(20'h20014)] == 16'h1002, "R6 burst data", mem[int'(20'h20014)], 16'h1002);

        // R7/R8: burst line read
        txn(20'h3FFF8, 1, 1, 2'b11, 16'h0, 0, 0);
        check(n_re == 4, "R4 burst read beats", n_re, 4);
        check(last_out == {4'h0, rd_val(20'h3FFFE)}, "R7 last read data",
              last_out, {4'h0, rd_val(20'h3FFFE)});
        @(negedge clk);
        check(bus_oe === 0, "R8 released after deselect", bus_oe, 0);

        // R4: burst with non-line size
        txn(20'h05000, 1, 1, 2'b01, 16'h0, 0, 0);
        check(n_re == 1, "R4 burst small size", n_re, 1);

        // R5: wrap at top of window
        txn(20'hFFFFC, 1, 1, 2'b11, 16'h0, 0, 0);
        check(last_re_addr == 20'h00002, "R5 address wrap", last_re_addr, 20'h00002);

        // R9: abort during wait
        txn(20'h44440, 0, 1, 2'b11, 16'h2000, 1, 0);
        check(n_we == 0, "R9 abort no strobes", n_we, 0);

        // R10: stray start during wait
        txn(20'h55550, 0, 0, 2'b00, 16'h3333, 0, 1);
        check(last_we_addr == 20'h55550 && n_we == 1, "R10 stray ts ignored",
              last_we_addr, 20'h55550);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule